// File: doc/BRIEF.md
# Area-Lean 32-bit Integer ALU with Serial Shifter

This block is the integer execution unit of a small RISC-V style core where logic area matters more than latency. It takes two 32-bit operands, a 4-bit operation code and a start strobe. It returns a 32-bit result and an acknowledge. It covers addition, subtraction, bitwise AND, OR and XOR, signed and unsigned set-less-than, equality for branches, and the three shifts: left logical, right logical and right arithmetic.

A single 33-bit subtractor produces the difference and both orderings. For unsigned compare the borrow out of the 33-bit difference is the less-than answer. For signed compare the top bit of both operands is inverted before they enter the same subtractor. Equality reuses the XOR datapath, so the block has no separate comparator. The shifts run through a one-bit-per-cycle shifter. Every operation except a shift is acknowledged in the same cycle as its start. A shift is acknowledged only when it finishes.

The handshake has no back-pressure. `start` acts as the valid of a request. Requests are accepted whenever no shift is in flight and are silently dropped while one is. `ack` is a one-cycle valid for `result`, and the consumer must take the result in that cycle.

Top module: `rv_alu`

## Requirements
- R1: Op 0 (add) returns opa+opb and op 1 (sub) returns opa-opb, both modulo 2^32 with no overflow indication.
- R2: Op 2 returns opa AND opb, op 3 returns opa OR opb, and op 4 returns opa XOR opb.
- R3: Op 6 (unsigned less-than) returns 1 in bit 0 when opa < opb as unsigned numbers, else 0. Bits 31:1 are zero.
- R4: Op 5 (signed less-than) returns 1 in bit 0 when opa < opb as two's-complement numbers, else 0. Bits 31:1 are zero.
- R5: Op 7 (equality) returns 1 in bit 0 when opa equals opb, else 0. Bits 31:1 are zero.
- R6: For every op other than 8, 9 and 10, with start high and no shift in flight, ack is high in that same cycle and result holds the answer.
- R7: For ops 8, 9 and 10 the shift amount is opb[4:0]. With start high in cycle c and amount n, ack is low in cycles c through c+n and high for exactly one cycle, c+n+1. A shift by zero is therefore acknowledged in the cycle after start.
- R8: Op 8 shifts left filling with zeros. Op 9 shifts right filling with zeros. Op 10 shifts right filling with the original opa[31].
- R9: While a shift is in flight, start is ignored. No ack appears before the shift ends, and the shift's result is unaffected by operands or ops presented meanwhile.
- R10: During and right after reset, ack is low and no shift is in flight.
- R11: Op codes 11 to 15 return zero with a same-cycle ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe (valid) |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; bits 4:0 are the shift amount |
| result | output | 32 | Result, meaningful while ack is high |
| ack | output | 1 | One-cycle result valid |

## Verification
The bench targets signed compares where the operands differ in sign, since a design that skipped the top-bit inversion would invert those answers. It also covers equal operands, where an off-by-one borrow would report less-than for equal values. Shift amounts of 0 and 31 and negative operands on the arithmetic right shift are driven directly: a wrong counter would acknowledge a cycle early or late, and a wrong fill bit would corrupt the upper bits. The bench holds start high with other ops while a shift runs, because a design that accepted those requests would acknowledge early or overwrite the shift data.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned SHW  = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_EQ   = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/rv_alu_comb.sv
module rv_alu_comb
  import rv_alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic         signed_cmp;
  logic [W-1:0] flip;
  logic [W:0]   diff;
  logic         less;
  logic [W-1:0] xr;
  logic         same;
  logic [W-1:0] sum;

  assign signed_cmp = (op == OP_SLT);
  assign flip       = signed_cmp ? MSB_ONLY : '0;
  // One widened subtractor serves sub, slt and sltu; the msb flip cancels in the low bits.
  assign diff = {1'b0, a ^ flip} - {1'b0, b ^ flip};
  assign less = diff[W];
  assign xr   = a ^ b;
  assign same = ~|xr;
  assign sum  = a + b;

  always_comb begin
    res = '0;
    case (op)
      OP_ADD:  res = sum;
      OP_SUB:  res = diff[W-1:0];
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = xr;
      OP_SLT,
      OP_SLTU: res = {{(W-1){1'b0}}, less};
      OP_EQ:   res = {{(W-1){1'b0}}, same};
      default: res = '0;
    endcase
  end

  AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |-> (res + b == a)); // R1
  AST_CMP_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SLT || op == OP_SLTU || op == OP_EQ) |-> (res[W-1:1] == '0)); // R3
  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EQ) |-> (res[0] == (a == b))); // R5
  AST_SLTU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SLTU) |-> (res[0] == (a < b))); // R3
endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter
  import rv_alu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  shift_kind_e   kind,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  data_q;
  logic [CW-1:0] cnt_q;
  shift_kind_e   kind_q;
  logic          busy_q;
  logic [W-1:0]  step;

  always_comb begin
    case (kind_q)
      SH_LEFT: step = {data_q[W-2:0], 1'b0};
      SH_RARI: step = {data_q[W-1], data_q[W-1:1]};
      default: step = {1'b0, data_q[W-1:1]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
      kind_q <= SH_LEFT;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        data_q <= step;
      end
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= amt;
      data_q <= din;
      kind_q <= kind;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
  assign dout = data_q;

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(kind_q)); // R9
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind_q == SH_RARI && cnt_q != '0) |=> (data_q[W-1] == $past(data_q[W-1]))); // R8
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         ack
);
  localparam int unsigned CW = $clog2(W);

  alu_op_e      op_e;
  logic         is_shift;
  logic         sh_busy;
  logic         sh_done;
  logic [W-1:0] sh_out;
  logic [W-1:0] comb_res;
  logic         sh_load;
  logic         quick_ack;
  shift_kind_e  kind;

  assign op_e     = alu_op_e'(op);
  assign is_shift = (op_e == OP_SLL) || (op_e == OP_SRL) || (op_e == OP_SRA);
  assign sh_load  = start && !sh_busy && is_shift;
  assign quick_ack = start && !sh_busy && !is_shift;

  always_comb begin
    case (op_e)
      OP_SRL:  kind = SH_RLOG;
      OP_SRA:  kind = SH_RARI;
      default: kind = SH_LEFT;
    endcase
  end

  rv_alu_comb #(.W(W)) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op_e),
    .a     (opa),
    .b     (opb),
    .res   (comb_res)
  );

  rv_alu_shifter #(.W(W), .CW(CW)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .kind  (kind),
    .din   (opa),
    .amt   (opb[CW-1:0]),
    .busy  (sh_busy),
    .done  (sh_done),
    .dout  (sh_out)
  );

  assign ack    = sh_done || quick_ack;
  assign result = sh_busy ? sh_out : comb_res;

  AST_QUICK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sh_busy && !is_shift) |-> ack); // R6
  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && !sh_done) |-> !ack); // R9
  AST_SHIFT_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sh_busy && is_shift) |-> !ack); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sh_busy && !ack)); // R10
endmodule

// File: tb/tb_rv_alu.sv
module tb_rv_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] result;
  logic        ack;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  rv_alu dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
              .opa(opa), .opb(opb), .result(result), .ack(ack));

  always #4 clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return {31'd0, $signed(a) < $signed(b)};
      4'd6:  return {31'd0, a < b};
      4'd7:  return {31'd0, a == b};
      4'd8:  return a << b[4:0];
      4'd9:  return a >> b[4:0];
      4'd10: return $unsigned($signed(a) >>> b[4:0]);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3, 4'd4: return "R2";
      4'd5: return "R4";
      4'd6: return "R3";
      4'd7: return "R5";
      4'd8, 4'd9, 4'd10: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Non-shift op: ack and result in the start cycle (R6).
  task automatic run_quick(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    #1;
    check("R6", {31'd0, ack}, 32'd1);
    check(req_of(o), result, model(o, a, b));
    @(negedge clk);
    start = 1'b0;
  endtask

  // Shift op: ack exactly amount+1 cycles later (R7); optionally keep start high with noise (R9).
  task automatic run_shift(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input bit noisy);
    int n;
    logic [31:0] exp;
    n = b[4:0];
    exp = model(o, a, b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    #1;
    check("R7", {31'd0, ack}, 32'd0);
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      if (noisy) begin
        start = 1'b1; op = 4'(k % 11); opa = $urandom; opb = $urandom;
      end else begin
        start = 1'b0;
      end
      #1;
      if (k <= n) begin
        if (ack !== 1'b0) check(noisy ? "R9" : "R7", {31'd0, ack}, 32'd0);
      end else begin
        check("R7", {31'd0, ack}, 32'd1);
        check(noisy ? "R9" : req_of(o), result, exp);
      end
    end
    @(negedge clk);
    start = 1'b0;
    #1;
    check("R7", {31'd0, ack}, 32'd0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    check("R10", {31'd0, ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {31'd0, ack}, 32'd0);

    // Directed corner cases
    run_quick(4'd0, 32'hFFFF_FFFF, 32'd1);          // R1 wrap
    run_quick(4'd1, 32'd0, 32'd1);                  // R1 wrap
    run_quick(4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF);  // R2
    run_quick(4'd3, 32'hF0F0_0000, 32'h0000_1234);  // R2
    run_quick(4'd4, 32'hAAAA_5555, 32'hFFFF_0000);  // R2
    run_quick(4'd5, 32'h8000_0000, 32'd1);          // R4 negative < positive
    run_quick(4'd5, 32'd1, 32'h8000_0000);          // R4
    run_quick(4'd5, 32'h7FFF_FFFF, 32'h7FFF_FFFF);  // R4 equal
    run_quick(4'd6, 32'h8000_0000, 32'd1);          // R3
    run_quick(4'd6, 32'd5, 32'd5);                  // R3 equal
    run_quick(4'd6, 32'd0, 32'hFFFF_FFFF);          // R3
    run_quick(4'd7, 32'h1234_5678, 32'h1234_5678);  // R5
    run_quick(4'd7, 32'h1234_5678, 32'h1234_5679);  // R5
    run_quick(4'd12, 32'h1111_1111, 32'h2222_2222); // R11
    run_quick(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R11
    run_shift(4'd8, 32'h8000_0001, 32'd0, 1'b0);    // R7 zero shift
    run_shift(4'd8, 32'h0000_0001, 32'd31, 1'b0);   // R8
    run_shift(4'd9, 32'h8000_0000, 32'd31, 1'b0);   // R8
    run_shift(4'd10, 32'h8000_0000, 32'd31, 1'b0);  // R8 sign fill
    run_shift(4'd10, 32'h7000_0000, 32'hFFFF_FFE4, 1'b0); // R8 amount from low bits
    run_shift(4'd10, 32'hC000_1234, 32'd7, 1'b1);   // R9 noise during shift
    run_shift(4'd9, 32'hDEAD_BEEF, 32'd12, 1'b1);   // R9

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      logic [31:0] a, b;
      o = 4'($urandom_range(0, 15));
      a = $urandom;
      b = $urandom;
      if (($urandom & 3) == 0) b = a;
      if (o >= 4'd8 && o <= 4'd10) run_shift(o, a, b, ($urandom & 1) == 1);
      else run_quick(o, a, b);
    end

    // Reset in the middle of a shift
    @(negedge clk);
    start = 1'b1; op = 4'd8; opa = 32'd1; opb = 32'd20;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", {31'd0, ack}, 32'd0);
    run_quick(4'd0, 32'd2, 32'd3);                  // accepted at once: nothing in flight

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule